// File: doc/BRIEF.md
# Timer Pin Role, GPIO Drive and Edge-Interrupt Controller

This block owns the single I/O pin of one general purpose timer channel. Software configures it through a 32-bit configuration word that chooses what the pin is used for (disabled, input capture, output compare, PWM or plain GPIO), how a GPIO output is driven, whether the interrupt line is enabled, and which pin edges count as capture events. A second word, the event word, reports sticky event flags and the live, synchronized level of the pin.

In GPIO role the pin can be left floating as an input, driven low or driven high. Setting the open-drain bit turns a high output into a released pin. In capture role the pin is input only: the selected edges set sticky flags, and these raise one interrupt line while the enable bit is on. A flag is cleared by writing 1 to its position in the event word. The counter, the prescaler and the waveform of the compare and PWM roles are outside this block. In those roles the pin is left undriven here.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: After reset the configuration word reads 0, the event flags (event word bits [3:0]) read 0, `pin_oe` is 0 and `irq` is 0.
- R2: A write with `wr_addr`=0 stores all 32 bits of the configuration word. A read with `rd_addr`=0 returns the stored value unchanged.
- R3: With role bits [2:0]=4 (GPIO), drive bits [5:4]=10 give `pin_oe`=1 with `pin_out`=0, 11 give `pin_oe`=1 with `pin_out`=1, and 00 give `pin_oe`=0. The outputs change in the cycle after the write.
- R4: With open-drain bit 9 set in GPIO role, drive 11 releases the pin (`pin_oe`=0, `pin_out`=0), while drive 10 still drives it low.
- R5: In any role other than GPIO (for example role 1, capture), `pin_oe` stays 0 whatever the drive bits hold.
- R6: Event word bit 8 (`rd_addr`=1) shows the level of `pin_in` two clock edges after it changes.
- R7: In role 1 (capture) with edge bits [17:16]=01, a rising pin edge sets flag bit 0 (any selected event) and bit 1 (event was rising) on the third clock edge after the pin change. A falling edge sets nothing.
- R8: Edge bits 10 select only falling edges, which set flags bit 0 and bit 2 (event was falling). Edge bits 11 select both edges. Edge bits 00 select none.
- R9: A selected event that occurs while flag bit 0 is already set also sets flag bit 3 (overrun).
- R10: Flags are sticky. A write with `wr_addr`=1 clears each flag whose data bit is 1 and leaves flags written with 0. An event in the same cycle as the clear sets its flags anyway.
- R11: `irq` is 1 while any flag is set and configuration bit 8 is 1. Clearing bit 8 forces `irq` to 0 but leaves the flags as they are, so setting bit 8 again raises `irq` again.
- R12: Outside role 1 no pin edge sets any flag, whatever the edge bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | Write target: 0 configuration word, 1 event word (write-1-to-clear) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read select: 0 configuration word, 1 event word |
| rd_data | output | 32 | Read data for the selected word (combinational) |
| pin_in | input | 1 | Asynchronous level seen at the pin |
| pin_oe | output | 1 | Pin output enable |
| pin_out | output | 1 | Pin output value |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a 32-bit bus and four event flags. With these settings the pin level appears in the event word exactly two edges after a pin change, and a flag appears on the third edge. The bench samples on both sides of those boundaries. It can also place a clear write on the same edge as a capture event, which exercises the rule that the event wins.

// File: rtl/tpin_pkg.sv
package tpin_pkg;

    localparam int BUS_W     = 32;
    localparam int FLAG_W    = 4;
    localparam int ROLE_LSB  = 0;
    localparam int DRIVE_LSB = 4;
    localparam int IRQEN_BIT = 8;
    localparam int OD_BIT    = 9;
    localparam int EDGE_LSB  = 16;
    localparam int LEVEL_BIT = 8;

    // flag positions
    localparam int F_EVENT   = 0;
    localparam int F_RISE    = 1;
    localparam int F_FALL    = 2;
    localparam int F_OVERRUN = 3;

    typedef enum logic [2:0] {
        ROLE_OFF     = 3'd0,
        ROLE_CAPTURE = 3'd1,
        ROLE_COMPARE = 3'd2,
        ROLE_PWM     = 3'd3,
        ROLE_GPIO    = 3'd4
    } pin_role_e;

    typedef struct packed {
        logic [1:0] edge_sel;
        logic       open_drain;
        logic       irq_en;
        logic [1:0] drive;
        logic [2:0] role;
    } mode_fields_t;

    function automatic mode_fields_t decode_mode(input logic [BUS_W-1:0] r);
        mode_fields_t m;
        m.role       = r[ROLE_LSB +: 3];
        m.drive      = r[DRIVE_LSB +: 2];
        m.irq_en     = r[IRQEN_BIT];
        m.open_drain = r[OD_BIT];
        m.edge_sel   = r[EDGE_LSB +: 2];
        return m;
    endfunction

    function automatic logic [BUS_W-1:0] build_status(input logic [FLAG_W-1:0] f,
                                                      input logic lvl);
        logic [BUS_W-1:0] s;
        s = '0;
        s[FLAG_W-1:0] = f;
        s[LEVEL_BIT]  = lvl;
        return s;
    endfunction

endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q[0] <= 1'b0;
                    else     q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q[i] <= 1'b0;
                    else     q[i] <= q[i-1];
                end
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/tpin_flags.sv
module tpin_flags
    import tpin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [1:0]        edge_sel,
    input  logic              lvl,
    input  logic              clr_stb,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] flags
);
    logic              prev;
    logic              rise, fall, sel_rise, sel_fall, evt;
    logic [FLAG_W-1:0] set_vec, keep_mask;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    always_comb begin
        rise     = lvl & ~prev;
        fall     = ~lvl & prev;
        sel_rise = cap_en & rise & edge_sel[0];
        sel_fall = cap_en & fall & edge_sel[1];
        evt      = sel_rise | sel_fall;
        set_vec            = '0;
        set_vec[F_EVENT]   = evt;
        set_vec[F_RISE]    = sel_rise;
        set_vec[F_FALL]    = sel_fall;
        set_vec[F_OVERRUN] = evt & flags[F_EVENT];
        keep_mask = clr_stb ? ~clr_mask : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & keep_mask) | set_vec;
    end

    AST_NO_SET_OUTSIDE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> ((flags & ~$past(flags)) == '0)); // R12
    AST_CLEAR_EFFECTIVE: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && !evt) |=> ((flags & $past(clr_mask)) == '0)); // R10
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_stb |=> ((~flags & $past(flags)) == '0)); // R10
endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
    import tpin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] role,
    input  logic [1:0] drive,
    input  logic       open_drain,
    output logic       pin_oe,
    output logic       pin_out
);
    logic gpio_role, want_drive, release_high;

    always_comb begin
        gpio_role    = (role == ROLE_GPIO);
        want_drive   = gpio_role & drive[1];
        release_high = open_drain & drive[0];
        pin_oe       = want_drive & ~release_high;
        pin_out      = pin_oe & drive[0];
    end

    AST_ROLE_GATES_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (role != ROLE_GPIO) |-> !pin_oe); // R5
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (open_drain && pin_oe) |-> !pin_out); // R4
endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
    import tpin_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [BUS_W-1:0] rd_data,
    input  logic             pin_in,
    output logic             pin_oe,
    output logic             pin_out,
    output logic             irq
);
    logic [BUS_W-1:0]  mode_q;
    mode_fields_t      mf;
    logic              lvl;
    logic [FLAG_W-1:0] flags;
    logic              clr_stb, cap_en;

    always_ff @(posedge clk) begin
        if (rst)                       mode_q <= '0;
        else if (wr_en && !wr_addr)    mode_q <= wr_data;
    end

    always_comb begin
        mf      = decode_mode(mode_q);
        clr_stb = wr_en & wr_addr;
        cap_en  = (mf.role == ROLE_CAPTURE);
        irq     = (|flags) & mf.irq_en;
        rd_data = rd_addr ? build_status(flags, lvl) : mode_q;
    end

    tpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(pin_in), .dout(lvl)
    );

    tpin_flags u_flags (
        .clk(clk), .rst(rst), .cap_en(cap_en), .edge_sel(mf.edge_sel),
        .lvl(lvl), .clr_stb(clr_stb), .clr_mask(wr_data[FLAG_W-1:0]),
        .flags(flags)
    );

    tpin_drive u_drive (
        .clk(clk), .rst(rst), .role(mf.role), .drive(mf.drive),
        .open_drain(mf.open_drain), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !mode_q[IRQEN_BIT] |-> !irq); // R11
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rd_addr ? (rd_data[FLAG_W-1:0] != '0) : 1'b1)); // R11
endmodule

// File: tb/tmr_pin_ctrl_test.sv
module tmr_pin_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        pin_in = 1'b0;
    logic        pin_oe, pin_out, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_pin_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle_low;
        wr(1'b0, 32'h0);
        pin_in = 1'b0;
        cyc(4);
        wr(1'b1, 32'hF);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(1'b0, v); check("R1 mode after reset", v, 32'h0);
        rd(1'b1, v); check("R1 flags after reset", {28'h0, v[3:0]}, 32'h0);
        check("R1 pin_oe after reset", {31'h0, pin_oe}, 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_mode_rw;
        logic [31:0] v;
        wr(1'b0, 32'hA5C3_3C5A);
        rd(1'b0, v); check("R2 mode readback", v, 32'hA5C3_3C5A);
        wr(1'b0, 32'h0);
        rd(1'b0, v); check("R2 mode readback zero", v, 32'h0);
    endtask

    task automatic t_gpio;
        wr(1'b0, 32'h24);
        check("R3 drive low oe", {31'h0, pin_oe}, 32'h1);
        check("R3 drive low out", {31'h0, pin_out}, 32'h0);
        wr(1'b0, 32'h34);
        check("R3 drive high oe", {31'h0, pin_oe}, 32'h1);
        check("R3 drive high out", {31'h0, pin_out}, 32'h1);
        wr(1'b0, 32'h04);
        check("R3 input oe", {31'h0, pin_oe}, 32'h0);
    endtask

    task automatic t_open_drain;
        wr(1'b0, 32'h234);
        check("R4 od high released", {30'h0, pin_oe, pin_out}, 32'h0);
        wr(1'b0, 32'h224);
        check("R4 od low driven", {30'h0, pin_oe, pin_out}, 32'h2);
    endtask

    task automatic t_capture_no_drive;
        wr(1'b0, 32'h3_0131);
        check("R5 capture ignores drive", {31'h0, pin_oe}, 32'h0);
        wr(1'b0, 32'h32);
        check("R5 compare role undriven", {31'h0, pin_oe}, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        settle_low();
        pin_in = 1'b1;
        cyc(1); rd(1'b1, v); check("R6 level not yet", {31'h0, v[8]}, 32'h0);
        cyc(1); rd(1'b1, v); check("R6 level after two edges", {31'h0, v[8]}, 32'h1);
        pin_in = 1'b0;
        cyc(2); rd(1'b1, v); check("R6 level low again", {31'h0, v[8]}, 32'h0);
    endtask

    task automatic t_rise;
        logic [31:0] v;
        settle_low();
        wr(1'b0, 32'h1_0001);
        pin_in = 1'b1;
        cyc(2); rd(1'b1, v); check("R7 flag not before third edge", {28'h0, v[3:0]}, 32'h0);
        cyc(1); rd(1'b1, v); check("R7 rising event flags", {28'h0, v[3:0]}, 32'h3);
        wr(1'b1, 32'hF);
        pin_in = 1'b0;
        cyc(4); rd(1'b1, v); check("R7 falling ignored", {28'h0, v[3:0]}, 32'h0);
    endtask

    task automatic t_fall_both;
        logic [31:0] v;
        settle_low();
        wr(1'b0, 32'h2_0001);
        pin_in = 1'b1;
        cyc(4); rd(1'b1, v); check("R8 falling-only ignores rise", {28'h0, v[3:0]}, 32'h0);
        pin_in = 1'b0;
        cyc(3); rd(1'b1, v); check("R8 falling event flags", {28'h0, v[3:0]}, 32'h5);
        wr(1'b1, 32'hF);
        wr(1'b0, 32'h3_0001);
        pin_in = 1'b1;
        cyc(3); rd(1'b1, v); check("R8 both: rise", {28'h0, v[3:0]}, 32'h3);
        wr(1'b1, 32'hF);
        pin_in = 1'b0;
        cyc(3); rd(1'b1, v); check("R8 both: fall", {28'h0, v[3:0]}, 32'h5);
        wr(1'b1, 32'hF);
        wr(1'b0, 32'h0_0001);
        pin_in = 1'b1; cyc(4);
        pin_in = 1'b0; cyc(4);
        rd(1'b1, v); check("R8 no edge selected", {28'h0, v[3:0]}, 32'h0);
    endtask

    task automatic t_overrun;
        logic [31:0] v;
        settle_low();
        wr(1'b0, 32'h3_0001);
        pin_in = 1'b1;
        cyc(3); rd(1'b1, v); check("R9 first event", {28'h0, v[3:0]}, 32'h3);
        pin_in = 1'b0;
        cyc(3); rd(1'b1, v); check("R9 overrun set", {28'h0, v[3:0]}, 32'hF);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(1'b1, 32'h2);
        rd(1'b1, v); check("R10 clear one bit", {28'h0, v[3:0]}, 32'hD);
        wr(1'b1, 32'h0);
        rd(1'b1, v); check("R10 zero write keeps", {28'h0, v[3:0]}, 32'hD);
        wr(1'b1, 32'hD);
        rd(1'b1, v); check("R10 clear rest", {28'h0, v[3:0]}, 32'h0);
        settle_low();
        wr(1'b0, 32'h1_0001);
        pin_in = 1'b1;
        cyc(2);
        wr(1'b1, 32'hF);
        rd(1'b1, v); check("R10 event beats clear", {28'h0, v[3:0]}, 32'h3);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        settle_low();
        wr(1'b0, 32'h1_0101);
        check("R11 irq idle", {31'h0, irq}, 32'h0);
        pin_in = 1'b1;
        cyc(3); check("R11 irq on event", {31'h0, irq}, 32'h1);
        wr(1'b0, 32'h1_0001);
        check("R11 irq masked", {31'h0, irq}, 32'h0);
        rd(1'b1, v); check("R11 flags kept while masked", {28'h0, v[3:0]}, 32'h3);
        wr(1'b0, 32'h1_0101);
        check("R11 irq re-enabled", {31'h0, irq}, 32'h1);
        wr(1'b1, 32'hF);
        check("R11 irq after clear", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_other_roles;
        logic [31:0] v;
        settle_low();
        wr(1'b0, 32'h3_0104);
        pin_in = 1'b1; cyc(4);
        pin_in = 1'b0; cyc(4);
        rd(1'b1, v); check("R12 gpio role no flags", {28'h0, v[3:0]}, 32'h0);
        wr(1'b0, 32'h3_0103);
        pin_in = 1'b1; cyc(4);
        pin_in = 1'b0; cyc(4);
        rd(1'b1, v); check("R12 pwm role no flags", {28'h0, v[3:0]}, 32'h0);
        check("R12 no irq", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_mode_rw();
        t_gpio();
        t_open_drain();
        t_capture_no_drive();
        t_level();
        t_rise();
        t_fall_both();
        t_overrun();
        t_w1c();
        t_irq();
        t_other_roles();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule